// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves eight-bit data between two ports, side A and side B, in either direction. Each direction owns a storage register. The data sent toward a port is either the live value now present on the opposite port or the copy held in that direction's register. Each port is modelled as three separate vectors: an input that always carries the value seen on the pins, an output, and an output-enable. No tristate logic exists inside the block.

Each register loads on the rising edge of its own store strobe. The strobes are synchronous pulse inputs, sampled on the system clock. The select and enable inputs have no effect on loading. A register therefore also captures data that the block is driving onto its own port. This is how one side's data can be copied into both registers.

Parameters choose how the enables are decoded and whether data is complemented on transfer. The enable style is either two independent enables or one shared enable with a direction bit. A further option registers the source selects so that each output changes source only on a clock edge.

Top module: `xcvr_regbus`

## Requirements
- R1: A synchronous active-high reset clears both storage registers and the strobe history. With a select held high after reset, the output of that direction shows the cleared register, which is 0x00 (0xFF when inverting).
- R2: A register loads the value on its source input pins at the first clock edge where its strobe is sampled high after being sampled low. The new content is visible after that edge. A strobe held high does not load again.
- R3: Loading happens whatever the values of the selects, mode_b and gate_n.
- R4: With a select at 0, that direction's output follows the live input of the opposite port in the same cycle. sel_ab steers b_out from a_in, and sel_ba steers a_out from b_in.
- R5: With a select at 1, that direction's output shows its storage register. A->B uses the register loaded from a_in, and B->A uses the register loaded from b_in.
- R6: In the split control style, mode_b=1 drives port B and gate_n=0 drives port A, independently. Both ports may be driven together. Each output-enable vector is all ones when its port is driven and all zeros otherwise.
- R7: In the shared control style, gate_n=1 drives neither port. gate_n=0 with mode_b=0 drives port A only. gate_n=0 with mode_b=1 drives port B only. Both ports are never driven at once.
- R8: The output data vectors carry the selected value whether or not the matching output-enable is asserted.
- R9: With INVERT=1, every transfer path, live or stored, delivers the bitwise complement. The registers still hold the true pin values.
- R10: With SEL_REG=1, an output changes source one cycle after its select changes. In the cycle where the select changes, the output still shows the previous source.
- R11: Data the block drives onto a port is captured by that port's register when its strobe rises. This copies one side's value into both registers.
- R12: Strobes rising in the same cycle load both registers from the input pin values present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Value seen on port A pins |
| a_out | output | W | Data toward port A |
| a_oe | output | W | Port A drive enable, all ones or all zeros |
| b_in | input | W | Value seen on port B pins |
| b_out | output | W | Data toward port B |
| b_oe | output | W | Port B drive enable, all ones or all zeros |
| stb_ab | input | 1 | Store strobe of the A->B register (loads from a_in) |
| stb_ba | input | 1 | Store strobe of the B->A register (loads from b_in) |
| sel_ab | input | 1 | A->B source: 0 live, 1 stored |
| sel_ba | input | 1 | B->A source: 0 live, 1 stored |
| mode_b | input | 1 | Split style: B enable, active high. Shared style: direction, 1 = toward B |
| gate_n | input | 1 | Split style: A enable, active low. Shared style: common enable, active low |

## Verification
The bench drives a strobe held high for several cycles while the data changes. A design that loads on level instead of on the edge would pick up the later data. It also loads a register while all enables are off and the selects point at stored data; an implementation that gates loading by those inputs would keep stale contents. Echoing driven data back onto a port while that port's strobe rises checks the copy-into-both-registers case, and firing both strobes in one cycle checks simultaneous loads. A second instance uses the shared-enable style, inversion and registered selects. It shows any decode that drives both ports, any path that skips the complement, and any select change that takes effect in the same cycle instead of one cycle later.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    CTL_SPLIT  = 1'b0,
    CTL_SHARED = 1'b1
  } ctl_style_e;

  typedef struct packed {
    logic to_a;
    logic to_b;
  } drive_t;

  // Enable decoding for both control styles
  function automatic drive_t decode_drive(input ctl_style_e st,
                                          input logic mode_b,
                                          input logic gate_n);
    drive_t d;
    if (st == CTL_SPLIT) begin
      d.to_b = mode_b;
      d.to_a = !gate_n;
    end else begin
      d.to_b = !gate_n && mode_b;
      d.to_a = !gate_n && !mode_b;
    end
    return d;
  endfunction

endpackage

// File: rtl/xcvr_strobe_edge.sv
module xcvr_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  output logic rise
);
  logic stb_q;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= stb;
  end

  assign rise = stb && !stb_q;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> (q == $past(d)));

  // R2
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(q));

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int W       = 8,
  parameter bit INVERT  = 1'b0,
  parameter bit SEL_REG = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout,
  output logic         sel_used
);
  function automatic logic [W-1:0] xfer(input logic [W-1:0] v);
    return INVERT ? ~v : v;
  endfunction

  if (SEL_REG) begin : g_sel_reg
    logic sel_q;
    always_ff @(posedge clk) begin
      if (rst) sel_q <= 1'b0;
      else     sel_q <= sel;
    end
    assign sel_used = sel_q;

    // R10
    sel_lag_chk: assert property (@(posedge clk) disable iff (rst)
      (sel != $past(sel)) |-> (sel_used == $past(sel)));
  end else begin : g_sel_direct
    assign sel_used = sel;
  end

  always_comb begin
    dout = xfer(sel_used ? stored : live);
  end

endmodule

// File: rtl/xcvr_regbus.sv
module xcvr_regbus
  import xcvr_pkg::*;
#(
  parameter int         W         = 8,
  parameter ctl_style_e CTL_STYLE = CTL_SPLIT,
  parameter bit         INVERT    = 1'b0,
  parameter bit         SEL_REG   = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         stb_ab,
  input  logic         stb_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         mode_b,
  input  logic         gate_n
);
  localparam int NDIR = 2;

  logic [NDIR-1:0][W-1:0] din, dout, stored;
  logic [NDIR-1:0]        stb, sel, rise, sel_used;
  drive_t                 drv;

  // index 0: A toward B, index 1: B toward A
  assign din[0] = a_in;
  assign din[1] = b_in;
  assign stb    = {stb_ba, stb_ab};
  assign sel    = {sel_ba, sel_ab};

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    xcvr_strobe_edge u_edge (
      .clk  (clk),
      .rst  (rst),
      .stb  (stb[g]),
      .rise (rise[g])
    );
    xcvr_store #(.W(W)) u_store (
      .clk (clk),
      .rst (rst),
      .ld  (rise[g]),
      .d   (din[g]),
      .q   (stored[g])
    );
    xcvr_path #(.W(W), .INVERT(INVERT), .SEL_REG(SEL_REG)) u_path (
      .clk      (clk),
      .rst      (rst),
      .sel      (sel[g]),
      .live     (din[g]),
      .stored   (stored[g]),
      .dout     (dout[g]),
      .sel_used (sel_used[g])
    );
  end

  assign b_out = dout[0];
  assign a_out = dout[1];

  assign drv  = decode_drive(CTL_STYLE, mode_b, gate_n);
  assign b_oe = {W{drv.to_b}};
  assign a_oe = {W{drv.to_a}};

  // R6
  oe_whole_chk: assert property (@(posedge clk) disable iff (rst)
    (a_oe == '0 || a_oe == '1) && (b_oe == '0 || b_oe == '1));

  // R7
  one_side_chk: assert property (@(posedge clk) disable iff (rst)
    (CTL_STYLE == CTL_SHARED) |-> !(a_oe[0] && b_oe[0]));

  // R5
  stored_b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_used[0] && !rise[0]) |=> (!sel_used[0] || $stable(b_out)));

  // R5
  stored_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_used[1] && !rise[1]) |=> (!sel_used[1] || $stable(a_out)));

endmodule

// File: tb/xcvr_regbus_tb.sv
`timescale 1ns/1ps
module xcvr_regbus_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] a_in, b_in;
  logic       stb_ab, stb_ba, sel_ab, sel_ba, mode_b, gate_n;
  logic [7:0] ia_out, ia_oe, ib_out, ib_oe;
  logic [7:0] ja_out, ja_oe, jb_out, jb_oe;

  int nchk = 0;
  int nbad = 0;

  // bench reference state
  logic [7:0] m_ra, m_rb;
  logic       m_sq_ab, m_sq_ba, m_selq_ab, m_selq_ba;

  always #2.5 clk = ~clk;

  xcvr_regbus dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(ia_out), .a_oe(ia_oe),
    .b_in(b_in), .b_out(ib_out), .b_oe(ib_oe), .stb_ab(stb_ab), .stb_ba(stb_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .mode_b(mode_b), .gate_n(gate_n)
  );

  xcvr_regbus #(.W(8), .CTL_STYLE(xcvr_pkg::CTL_SHARED), .INVERT(1'b1), .SEL_REG(1'b1)) dut_j (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(ja_out), .a_oe(ja_oe),
    .b_in(b_in), .b_out(jb_out), .b_oe(jb_oe), .stb_ab(stb_ab), .stb_ba(stb_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .mode_b(mode_b), .gate_n(gate_n)
  );

  function automatic logic [7:0] pick(input logic s, input logic [7:0] live, input logic [7:0] kept);
    if (s) return kept;
    return live;
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic vec(input logic [7:0] a, input logic [7:0] b, input logic sab_stb,
                     input logic sba_stb, input logic s_ab, input logic s_ba,
                     input logic mb, input logic gn, input string tag);
    string td, to_i, to_j;
    @(negedge clk);
    a_in = a; b_in = b; stb_ab = sab_stb; stb_ba = sba_stb;
    sel_ab = s_ab; sel_ba = s_ba; mode_b = mb; gate_n = gn;
    #1;
    td   = (tag != "") ? tag : (s_ab ? "R5" : "R4");
    to_i = (tag != "") ? tag : "R6";
    to_j = (tag != "") ? tag : "R7";
    chk(td, "i.b_out", ib_out, pick(s_ab, a, m_ra));
    chk((tag != "") ? tag : (s_ba ? "R5" : "R4"), "i.a_out", ia_out, pick(s_ba, b, m_rb));
    chk(to_i, "i.b_oe", ib_oe, {8{mb}});
    chk(to_i, "i.a_oe", ia_oe, {8{!gn}});
    chk((tag != "") ? tag : "R9", "j.b_out", jb_out, ~pick(m_selq_ab, a, m_ra));
    chk((tag != "") ? tag : "R9", "j.a_out", ja_out, ~pick(m_selq_ba, b, m_rb));
    chk(to_j, "j.b_oe", jb_oe, {8{!gn && mb}});
    chk(to_j, "j.a_oe", ja_oe, {8{!gn && !mb}});
    // model the coming clock edge
    if (sab_stb && !m_sq_ab) m_ra = a;
    if (sba_stb && !m_sq_ba) m_rb = b;
    m_sq_ab = sab_stb; m_sq_ba = sba_stb;
    m_selq_ab = s_ab;  m_selq_ba = s_ba;
  endtask

  initial begin
    #(200000 * 5);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    rst = 1'b1;
    a_in = '0; b_in = '0; stb_ab = 0; stb_ba = 0;
    sel_ab = 0; sel_ba = 0; mode_b = 0; gate_n = 1;
    m_ra = '0; m_rb = '0; m_sq_ab = 0; m_sq_ba = 0; m_selq_ab = 0; m_selq_ba = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: cleared registers visible through stored paths
    vec(8'hC3, 8'h3C, 0, 0, 1, 1, 1, 0, "R1");
    vec(8'hC3, 8'h3C, 0, 0, 1, 1, 1, 0, "R1");

    // R2: edge load, then held strobe with new data must not reload
    vec(8'hA5, 8'h5A, 1, 1, 1, 1, 1, 0, "R2");
    vec(8'h0F, 8'hF0, 1, 1, 1, 1, 1, 0, "R2");
    vec(8'h77, 8'h88, 1, 1, 1, 1, 1, 0, "R2");
    vec(8'h77, 8'h88, 0, 0, 1, 1, 1, 0, "R2");

    // R3: load with every enable off and selects on stored data
    vec(8'h12, 8'h34, 1, 1, 1, 1, 0, 1, "R3");
    vec(8'h00, 8'h00, 0, 0, 1, 1, 0, 1, "R3");
    // R8: data present while nothing is driven
    vec(8'h96, 8'h69, 0, 0, 0, 0, 0, 1, "R8");

    // R11: B driven live onto A, echoed on a_in, captured by the A-side register
    vec(8'h5E, 8'h5E, 1, 0, 0, 0, 0, 0, "R11");
    vec(8'h00, 8'h00, 0, 1, 1, 0, 1, 0, "R11");
    vec(8'h00, 8'h00, 0, 0, 1, 1, 1, 0, "R11");

    // R12: simultaneous strobes
    vec(8'h11, 8'h22, 1, 1, 0, 0, 1, 1, "R12");
    vec(8'hEE, 8'hDD, 0, 0, 1, 1, 1, 0, "R12");

    // R10: select toggling, registered-select instance lags by one cycle
    vec(8'h40, 8'h04, 0, 0, 0, 0, 1, 0, "R10");
    vec(8'h40, 8'h04, 0, 0, 1, 1, 1, 0, "R10");
    vec(8'h41, 8'h14, 0, 0, 0, 1, 1, 0, "R10");
    vec(8'h42, 8'h24, 0, 0, 1, 0, 0, 0, "R10");

    // R6 and R7: every enable combination
    for (int k = 0; k < 4; k++) vec(8'h3A, 8'hA3, 0, 0, k[0], k[1], k[0], k[1], "R6");
    for (int k = 0; k < 4; k++) vec(8'h3B, 8'hB3, 0, 0, k[1], k[0], k[0], k[1], "R7");

    // mixed random traffic, R9 covered on the inverting instance
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      r = $urandom;
      vec(r[7:0], r[15:8], r[16] & r[17], r[18] & r[19], r[20], r[21], r[22], r[23], "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule